// File: doc/BRIEF.md
# Byte-Addressed Peripheral Register Space with Single-Bit Operations

This block holds the small register window that an 8-bit processor core uses to talk to its on-chip peripherals. The core can reach it in two ways. A direct port decodes 64 byte locations at I/O addresses 0x00 to 0x3F. A second path reaches the same registers through the data address space, shifted up by 0x20. The lower half of the window (I/O addresses 0x00 to 0x1F) also accepts single-bit set, clear and test operations. Set and clear are carried out as a read of the whole byte, a change of one bit and a write of all eight bits back.

The sample contents are three plain scratch bytes, a status byte and a 9-bit memory-pointer pair. In the status byte, hardware events raise flags and software lowers them by writing ones. The pointer pair keeps only bit 0 in its high byte. Because bit set and clear write back every bit they read, running them on the status byte also lowers any other flag that was up at the time. The block reproduces this on purpose. Reads, bit-test results and the error strobe are combinational in the access cycle. Register updates take effect at the following rising clock edge.

Top module: `ioreg_space`

## Requirements
- R1: On the direct port (`acc_dspace`=0), I/O addresses 0x00 to 0x3F are decoded. A byte write (op 1) to scratch address 0x04, 0x05 or 0x24 is returned by a later byte read (op 0) of the same address.
- R2: With `acc_dspace`=1, data address D in 0x20 to 0x5F reaches I/O address D-0x20. A data address outside that window reads 0, changes nothing and raises `acc_err`.
- R3: Bit set (op 2) and bit clear (op 3) at I/O addresses 0x00 to 0x1F write back the current byte with bit `acc_bit` forced to 1 or 0. The new value is visible from the next cycle.
- R4: Bit test (op 4) at I/O addresses 0x00 to 0x1F drives `acc_bit_val` with bit `acc_bit` of the addressed register in the same cycle. In every other case `acc_bit_val` is 0.
- R5: Bit set, clear and test at I/O addresses 0x20 to 0x3F are rejected: `acc_err` is 1 and no register changes. Op codes 5 to 7 are also rejected with `acc_err`.
- R6: Status byte at I/O 0x08. Flags sit in bits 3:0. Writing 1 to a flag bit lowers that flag and writing 0 leaves it alone. Bits 7:4 always read 0.
- R7: Bit set or clear on the status byte lowers every flag that read as 1 in that cycle, except a flag that bit clear targets.
- R8: A 1 on `hw_flag_set[i]` raises flag i at the next edge, even when the same cycle writes 1 to that flag.
- R9: Writes (byte write, bit set or bit clear) to unimplemented I/O addresses change nothing and raise `acc_err`. Byte reads of them return 0 without error.
- R10: The pointer low byte (I/O 0x10) is fully writable. The high byte (I/O 0x11) keeps only bit 0 and its bits 7:1 read 0. `ee_addr` presents {high bit 0, low byte}.
- R11: After reset every register and flag reads 0 and `ee_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access present this cycle |
| acc_dspace | input | 1 | 0 = direct I/O port, 1 = data-space alias |
| acc_addr | input | 8 | Access address |
| acc_op | input | 3 | 0 read, 1 write, 2 bit set, 3 bit clear, 4 bit test |
| acc_bit | input | 3 | Bit index for bit operations |
| acc_wdata | input | 8 | Byte write data |
| hw_flag_set | input | 4 | Hardware events raising status flags |
| acc_rdata | output | 8 | Byte read data (combinational) |
| acc_bit_val | output | 1 | Bit-test result (combinational) |
| acc_err | output | 1 | Rejected access strobe (combinational) |
| ee_addr | output | 9 | Current memory-pointer value |

## Verification
Plain byte writes and reads are run through both address paths, so that an error in the alias offset shows up as a wrong register. Bit set and clear are applied to a scratch byte with a mixed bit pattern, which separates a correct single-bit change from a whole-byte overwrite. They are also applied to the status byte with several flags up, which shows whether the read-modify-write side effect clears the other flags. Rejected cases follow each one with a read-back: bit operations in the upper half, reserved addresses, data addresses outside the window and bad op codes. Together they show whether the error strobe and the write suppression agree. A simultaneous hardware set and software clear separates the two possible priorities.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;

  typedef enum logic [2:0] {
    OP_RD   = 3'd0,
    OP_WR   = 3'd1,
    OP_BSET = 3'd2,
    OP_BCLR = 3'd3,
    OP_BTST = 3'd4
  } acc_op_e;

  // Force one bit of a byte to a value, keeping the rest as read.
  function automatic logic [7:0] bit_rmw(input logic [7:0] cur,
                                         input logic [2:0] idx,
                                         input logic       set_not_clr);
    logic [7:0] mask;
    mask = 8'b1 << idx;
    return set_not_clr ? (cur | mask) : (cur & ~mask);
  endfunction

  // Flags lowered by ones, then raised by events (events win).
  function automatic logic [3:0] flag_next(input logic [3:0] cur,
                                           input logic [3:0] clr_ones,
                                           input logic [3:0] raise);
    return (cur & ~clr_ones) | raise;
  endfunction

endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode
  import ioreg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IO_AW     = 6,
  parameter int DS_OFFSET = 32,
  parameter int BIT_LIMIT = 32
) (
  input  logic              dspace,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        op,
  output logic [IO_AW-1:0]  io_addr,
  output logic              addr_ok,
  output logic              is_write,
  output logic              is_rmw,
  output logic              is_set,
  output logic              is_test,
  output logic              bit_op,
  output logic              bit_ok,
  output logic              op_bad
);

  localparam int IO_SPAN = 1 << IO_AW;
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(DS_OFFSET);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(DS_OFFSET + IO_SPAN);
  localparam logic [ADDR_W:0] IO_TOP = (ADDR_W+1)'(IO_SPAN);
  localparam logic [IO_AW:0]  BIT_TOP = (IO_AW+1)'(BIT_LIMIT);

  logic [ADDR_W:0]   addr_ext;
  logic [ADDR_W-1:0] shifted;

  assign addr_ext = {1'b0, addr};
  assign shifted  = addr - ADDR_W'(DS_OFFSET);

  always_comb begin
    if (dspace) begin
      addr_ok = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
      io_addr = shifted[IO_AW-1:0];
    end else begin
      addr_ok = addr_ext < IO_TOP;
      io_addr = addr[IO_AW-1:0];
    end
  end

  assign is_write = (op == OP_WR);
  assign is_set   = (op == OP_BSET);
  assign is_rmw   = (op == OP_BSET) || (op == OP_BCLR);
  assign is_test  = (op == OP_BTST);
  assign bit_op   = is_rmw || is_test;
  assign bit_ok   = {1'b0, io_addr} < BIT_TOP;
  assign op_bad   = op > OP_BTST;

endmodule

// File: rtl/ioreg_file.sv
module ioreg_file
  import ioreg_pkg::*;
#(
  parameter int IO_AW     = 6,
  parameter int DATA_W    = 8,
  parameter int FLAG_W    = 4,
  parameter int EE_AW     = 9,
  parameter int NUM_SCR   = 3,
  parameter logic [NUM_SCR*IO_AW-1:0] SCR_ADDRS = {6'h24, 6'h05, 6'h04},
  parameter logic [IO_AW-1:0] STAT_ADDR = 6'h08,
  parameter logic [IO_AW-1:0] EEL_ADDR  = 6'h10,
  parameter logic [IO_AW-1:0] EEH_ADDR  = 6'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  rd_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] hw_set,
  output logic [DATA_W-1:0] rd_data,
  output logic              hit,
  output logic [EE_AW-1:0]  ee_addr
);

  localparam int EE_HI_W = EE_AW - DATA_W;

  // Scratch bytes
  logic [DATA_W-1:0] scr_q   [NUM_SCR];
  logic [NUM_SCR-1:0] scr_sel;

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    assign scr_sel[g] = (rd_addr == SCR_ADDRS[g*IO_AW +: IO_AW]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  scr_q[g] <= '0;
      else if (wr_en && scr_sel[g]) scr_q[g] <= wr_data;
    end

    assert_scr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && scr_sel[g]) |=> $stable(scr_q[g]));
  end

  // Status flags
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] flag_clr;
  logic              stat_sel;

  assign stat_sel = (rd_addr == STAT_ADDR);
  assign flag_clr = (wr_en && stat_sel) ? wr_data[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_next(flag_q, flag_clr, hw_set);
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag_chk
    assert_flag_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |-> $past(wr_en && stat_sel && wr_data[i]));
    assert_hw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[i] |=> flag_q[i]);
  end

  // Memory-pointer pair
  logic [DATA_W-1:0]  ee_lo_q;
  logic [EE_HI_W-1:0] ee_hi_q;
  logic               eel_sel;
  logic               eeh_sel;

  assign eel_sel = (rd_addr == EEL_ADDR);
  assign eeh_sel = (rd_addr == EEH_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ee_lo_q <= '0;
      ee_hi_q <= '0;
    end else if (wr_en) begin
      if (eel_sel) ee_lo_q <= wr_data;
      if (eeh_sel) ee_hi_q <= wr_data[EE_HI_W-1:0];
    end
  end

  assign ee_addr = {ee_hi_q, ee_lo_q};

  // Read mux and hit
  always_comb begin
    rd_data = '0;
    hit     = 1'b0;
    for (int k = 0; k < NUM_SCR; k++) begin
      if (scr_sel[k]) begin
        rd_data = rd_data | scr_q[k];
        hit     = 1'b1;
      end
    end
    if (stat_sel) begin
      rd_data = rd_data | {{(DATA_W-FLAG_W){1'b0}}, flag_q};
      hit     = 1'b1;
    end
    if (eel_sel) begin
      rd_data = rd_data | ee_lo_q;
      hit     = 1'b1;
    end
    if (eeh_sel) begin
      rd_data = rd_data | {{(DATA_W-EE_HI_W){1'b0}}, ee_hi_q};
      hit     = 1'b1;
    end
  end

endmodule

// File: rtl/ioreg_space.sv
module ioreg_space
  import ioreg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IO_AW     = 6,
  parameter int DATA_W    = 8,
  parameter int DS_OFFSET = 32,
  parameter int BIT_LIMIT = 32,
  parameter int FLAG_W    = 4,
  parameter int EE_AW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_dspace,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_op,
  input  logic [2:0]        acc_bit,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [FLAG_W-1:0] hw_flag_set,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_bit_val,
  output logic              acc_err,
  output logic [EE_AW-1:0]  ee_addr
);

  logic [IO_AW-1:0]  io_addr;
  logic              addr_ok, is_write, is_rmw, is_set, is_test;
  logic              bit_op, bit_ok, op_bad;
  logic [DATA_W-1:0] cur_byte;
  logic              hit;
  logic              wr_attempt;
  logic              wr_commit;
  logic [DATA_W-1:0] wr_byte;

  ioreg_decode #(
    .ADDR_W(ADDR_W), .IO_AW(IO_AW), .DS_OFFSET(DS_OFFSET), .BIT_LIMIT(BIT_LIMIT)
  ) u_decode (
    .dspace  (acc_dspace),
    .addr    (acc_addr),
    .op      (acc_op),
    .io_addr (io_addr),
    .addr_ok (addr_ok),
    .is_write(is_write),
    .is_rmw  (is_rmw),
    .is_set  (is_set),
    .is_test (is_test),
    .bit_op  (bit_op),
    .bit_ok  (bit_ok),
    .op_bad  (op_bad)
  );

  ioreg_file #(
    .IO_AW(IO_AW), .DATA_W(DATA_W), .FLAG_W(FLAG_W), .EE_AW(EE_AW)
  ) u_file (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_addr(io_addr),
    .wr_en  (wr_commit),
    .wr_data(wr_byte),
    .hw_set (hw_flag_set),
    .rd_data(cur_byte),
    .hit    (hit),
    .ee_addr(ee_addr)
  );

  // A write is wanted for byte writes and for bit set/clear in the low half.
  assign wr_attempt = is_write || (is_rmw && bit_ok);
  assign wr_commit  = acc_valid && addr_ok && wr_attempt && hit;
  assign wr_byte    = is_write ? acc_wdata : bit_rmw(cur_byte, acc_bit, is_set);

  assign acc_rdata   = (acc_valid && addr_ok) ? cur_byte : '0;
  assign acc_bit_val = acc_valid && addr_ok && is_test && bit_ok && cur_byte[acc_bit];
  assign acc_err     = acc_valid && (!addr_ok || op_bad || (bit_op && !bit_ok) ||
                                     (wr_attempt && !hit));

  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !addr_ok) |-> (acc_err && !wr_commit && acc_rdata == '0));

  assert_bit_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && addr_ok && bit_op && !bit_ok) |-> (acc_err && !wr_commit && !acc_bit_val));

  assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !wr_commit);

  assert_test_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bit_val |-> (acc_valid && is_test && !acc_err));

endmodule

// File: tb/ioreg_space_tb.sv
module ioreg_space_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_dspace = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [2:0] acc_op = '0;
  logic [2:0] acc_bit = '0;
  logic [7:0] acc_wdata = '0;
  logic [3:0] hw_flag_set = '0;
  logic [7:0] acc_rdata;
  logic       acc_bit_val;
  logic       acc_err;
  logic [8:0] ee_addr;

  int nvec = 0;
  int nfail = 0;

  logic [7:0] s_rdata;
  logic       s_bit;
  logic       s_err;

  localparam logic [2:0] RD = 3'd0, WR = 3'd1, BS = 3'd2, BC = 3'd3, BT = 3'd4;

  always #10 clk = ~clk;

  ioreg_space u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_dspace(acc_dspace),
    .acc_addr(acc_addr), .acc_op(acc_op), .acc_bit(acc_bit), .acc_wdata(acc_wdata),
    .hw_flag_set(hw_flag_set), .acc_rdata(acc_rdata), .acc_bit_val(acc_bit_val),
    .acc_err(acc_err), .ee_addr(ee_addr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One access: drive at negedge, sample combinational outputs, pass one edge.
  task automatic acc(input logic ds, input logic [7:0] a, input logic [2:0] op,
                     input logic [2:0] b, input logic [7:0] wd, input logic [3:0] hw);
    @(negedge clk);
    acc_valid = 1'b1; acc_dspace = ds; acc_addr = a; acc_op = op;
    acc_bit = b; acc_wdata = wd; hw_flag_set = hw;
    #2;
    s_rdata = acc_rdata; s_bit = acc_bit_val; s_err = acc_err;
    @(posedge clk); #1;
    acc_valid = 1'b0; hw_flag_set = '0;
  endtask

  task automatic rd_chk(input string tag, input logic ds, input logic [7:0] a,
                        input logic [7:0] exp);
    acc(ds, a, RD, 3'd0, 8'h00, 4'h0);
    chk(tag, {8'h00, s_rdata}, {8'h00, exp});
  endtask

  task automatic t_reset;
    rd_chk("R11 scratch 0x04", 0, 8'h04, 8'h00);
    rd_chk("R11 scratch 0x24", 0, 8'h24, 8'h00);
    rd_chk("R11 status", 0, 8'h08, 8'h00);
    chk("R11 ee_addr", {7'd0, ee_addr}, 16'h0000);
  endtask

  task automatic t_direct;
    acc(0, 8'h04, WR, 0, 8'hA5, 0);
    chk("R1 write err", {15'd0, s_err}, 16'h0000);
    acc(0, 8'h05, WR, 0, 8'h5A, 0);
    acc(0, 8'h24, WR, 0, 8'h3C, 0);
    rd_chk("R1 read 0x04", 0, 8'h04, 8'hA5);
    rd_chk("R1 read 0x05", 0, 8'h05, 8'h5A);
    rd_chk("R1 read 0x24", 0, 8'h24, 8'h3C);
  endtask

  task automatic t_alias;
    rd_chk("R2 data 0x24 -> io 0x04", 1, 8'h24, 8'hA5);
    rd_chk("R2 data 0x44 -> io 0x24", 1, 8'h44, 8'h3C);
    acc(1, 8'h25, WR, 0, 8'h77, 0);
    rd_chk("R2 data write seen at io 0x05", 0, 8'h05, 8'h77);
    acc(1, 8'h10, RD, 0, 8'h00, 0);
    chk("R2 below window err", {15'd0, s_err}, 16'h0001);
    chk("R2 below window rdata", {8'h00, s_rdata}, 16'h0000);
    acc(1, 8'h64, WR, 0, 8'hFF, 0);
    chk("R2 above window err", {15'd0, s_err}, 16'h0001);
    rd_chk("R2 no write from outside window", 0, 8'h04, 8'hA5);
    acc(0, 8'h44, WR, 0, 8'h11, 0);
    chk("R2 direct 0x44 out of range err", {15'd0, s_err}, 16'h0001);
    rd_chk("R2 0x24 untouched", 0, 8'h24, 8'h3C);
  endtask

  task automatic t_bits;
    acc(0, 8'h04, BS, 3'd1, 8'h00, 0);
    rd_chk("R3 bit set 1 on A5", 0, 8'h04, 8'hA7);
    acc(0, 8'h04, BC, 3'd7, 8'h00, 0);
    rd_chk("R3 bit clear 7", 0, 8'h04, 8'h27);
    acc(1, 8'h25, BS, 3'd3, 8'h00, 0);
    rd_chk("R3 bit set via data space", 0, 8'h05, 8'h7F);
    acc(0, 8'h04, BT, 3'd0, 8'h00, 0);
    chk("R4 test bit0 of 27", {15'd0, s_bit}, 16'h0001);
    acc(0, 8'h04, BT, 3'd3, 8'h00, 0);
    chk("R4 test bit3 of 27", {15'd0, s_bit}, 16'h0000);
    chk("R4 test no err", {15'd0, s_err}, 16'h0000);
  endtask

  task automatic t_reject;
    acc(0, 8'h24, BS, 3'd0, 8'h00, 0);
    chk("R5 bit set high err", {15'd0, s_err}, 16'h0001);
    rd_chk("R5 high reg unchanged", 0, 8'h24, 8'h3C);
    acc(0, 8'h24, BT, 3'd2, 8'h00, 0);
    chk("R5 bit test high err", {15'd0, s_err}, 16'h0001);
    chk("R5 bit test high val", {15'd0, s_bit}, 16'h0000);
    acc(0, 8'h04, 3'd5, 3'd0, 8'hFF, 0);
    chk("R5 bad op err", {15'd0, s_err}, 16'h0001);
    rd_chk("R5 bad op no change", 0, 8'h04, 8'h27);
  endtask

  task automatic t_status;
    acc(0, 8'h00, RD, 0, 8'h00, 4'b1011);
    rd_chk("R6 flags raised", 0, 8'h08, 8'h0B);
    acc(0, 8'h08, WR, 0, 8'h02, 0);
    rd_chk("R6 write one clears bit1", 0, 8'h08, 8'h09);
    acc(0, 8'h08, WR, 0, 8'hF0, 0);
    chk("R6 status write no err", {15'd0, s_err}, 16'h0000);
    rd_chk("R6 zeros and reserved bits no effect", 0, 8'h08, 8'h09);
    acc(0, 8'h08, BS, 3'd2, 8'h00, 0);
    rd_chk("R7 bit set clears others", 0, 8'h08, 8'h00);
    acc(0, 8'h00, RD, 0, 8'h00, 4'b1111);
    acc(0, 8'h08, BC, 3'd1, 8'h00, 0);
    rd_chk("R7 bit clear keeps target only", 0, 8'h08, 8'h02);
    acc(0, 8'h08, WR, 0, 8'h02, 4'b0010);
    rd_chk("R8 hw set beats clear", 0, 8'h08, 8'h02);
    acc(0, 8'h00, RD, 0, 8'h00, 4'b0001);
    rd_chk("R8 hw set alone", 1, 8'h28, 8'h03);
  endtask

  task automatic t_reserved;
    acc(0, 8'h00, WR, 0, 8'h55, 0);
    chk("R9 reserved write err", {15'd0, s_err}, 16'h0001);
    acc(0, 8'h00, RD, 0, 8'h00, 0);
    chk("R9 reserved read value", {8'h00, s_rdata}, 16'h0000);
    chk("R9 reserved read no err", {15'd0, s_err}, 16'h0000);
    acc(0, 8'h01, BS, 3'd0, 8'h00, 0);
    chk("R9 reserved bit set err", {15'd0, s_err}, 16'h0001);
    acc(0, 8'h3F, WR, 0, 8'hFF, 0);
    chk("R9 reserved high write err", {15'd0, s_err}, 16'h0001);
    rd_chk("R9 scratch unaffected", 0, 8'h24, 8'h3C);
  endtask

  task automatic t_pointer;
    acc(0, 8'h10, WR, 0, 8'hC3, 0);
    acc(1, 8'h31, WR, 0, 8'hFF, 0);
    rd_chk("R10 high byte reads bit0 only", 0, 8'h11, 8'h01);
    rd_chk("R10 low byte", 0, 8'h10, 8'hC3);
    chk("R10 ee_addr", {7'd0, ee_addr}, 16'h01C3);
    acc(0, 8'h11, BC, 3'd0, 8'h00, 0);
    chk("R10 ee_addr after bit clear", {7'd0, ee_addr}, 16'h00C3);
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_direct();
    t_alias();
    t_bits();
    t_reject();
    t_status();
    t_reserved();
    t_pointer();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule